// File: doc/BRIEF.md
# Back-to-Back Store Hazard Guard

This block sits in the decode stage of a SPARC-style integer pipeline, between the fetch stream and the issue logic. It sorts each incoming instruction word into a class (non-memory, memory access that is not a plain store, single-word-or-smaller store, doubleword store). It watches for two store orderings that can leave a data cache line out of date after a tag parity error. The two orderings are a doubleword store directly followed by any store, and a word-or-smaller store, then one non-memory instruction, then any store. When the incoming instruction would complete such an ordering, the block emits one NOP bubble in its place. It holds the real store back for that one transfer, then lets it through.

The stream uses a ready/valid handshake on both sides. The guard adds no register stage: a word that needs no bubble passes in the same cycle. An enable input turns insertion off, and the stream then passes through unchanged. A flush input forgets the recent history. A saturating counter reports how many bubbles the downstream stage has accepted.

Top module: `b2b_store_guard`

## Requirements
- R1: An instruction is a memory format word when bits [31:30] equal 2'b11, and its op3 field is bits [24:19]. It is a store when op3[3:2] equals 2'b01, which covers integer, alternate-space, floating-point and coprocessor stores. It is a doubleword store when op3[1:0] is also 2'b11, and a word-or-smaller store otherwise. The atomic op3 codes 0x0D, 0x0F, 0x1D, 0x1F, 0x3C and 0x3E are never stores. Every other memory format word is a non-store memory access, and every other word is a non-memory instruction.
- R2: A store that follows, in accepted order, a word-or-smaller store and exactly one non-memory instruction is preceded by one bubble.
- R3: A store that directly follows an accepted doubleword store is preceded by one bubble.
- R4: While a bubble is offered, out_bubble is 1, out_instr is 32'h0100_0000 and in_ready is 0. Once the bubble is accepted, the held store passes in the next transfer with no second bubble.
- R5: A non-store memory access (a load or an atomic) in either history slot prevents a match, and an atomic never counts as the second store.
- R6: Other orderings insert nothing: two non-memory instructions between stores, a doubleword store followed by a non-memory instruction and a store, or two back-to-back word stores.
- R7: With enable at 0, out_instr equals in_instr, in_ready equals out_ready and out_bubble is 0, all in the same cycle.
- R8: A cycle with flush at 1 empties the history, so a store presented after the flush is never preceded by a bubble because of instructions accepted before it.
- R9: bubble_count increments by one for each bubble accepted (out_valid, out_ready and out_bubble all 1). It stops at its all-ones value, with a default width of 16 bits.
- R10: out_valid follows in_valid. While out_ready is 0 nothing is consumed, the history does not advance, and a pending bubble stays offered.
- R11: After reset bubble_count is 0 and the history is empty, so the first store after reset passes without a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | 1 turns bubble insertion on |
| flush | input | 1 | Pipeline flush, empties the history |
| in_valid | input | 1 | Incoming instruction valid |
| in_ready | output | 1 | Incoming instruction consumed this cycle when valid |
| in_instr | input | 32 | Incoming instruction word |
| out_valid | output | 1 | Outgoing word valid |
| out_ready | input | 1 | Downstream accepts the outgoing word |
| out_instr | output | 32 | Outgoing instruction or bubble NOP |
| out_bubble | output | 1 | Outgoing word is an inserted bubble |
| bubble_count | output | CNT_W | Saturating count of accepted bubbles |

## Verification
On every cycle the assertions check the local rules. A bubble always stalls the input and carries the NOP word. Only a store can trigger one. An accepted bubble is never followed by a second one. A flush never leaves a bubble behind it. The disabled path is a plain pass-through. The counter steps or holds correctly and stays put at saturation. Whether a bubble appears for a particular three-instruction history, covering matched orderings, loads and atomics that break them, ASI and floating-point stores, and orderings that must not match, can only be shown by the bench's instruction sequences. The same holds for stalls with the bubble held, for flush, and for the saturation limit on a narrow counter.

// File: rtl/stg_pkg.sv
package stg_pkg;

  localparam int IW = 32;
  localparam logic [IW-1:0] BUBBLE_WORD = 32'h0100_0000;

  typedef enum logic [1:0] {
    CLS_PLAIN     = 2'd0,
    CLS_MEM       = 2'd1,
    CLS_ST_SMALL  = 2'd2,
    CLS_ST_DOUBLE = 2'd3
  } iclass_t;

  function automatic logic is_atomic(input logic [5:0] op3);
    return (op3 == 6'h0D) || (op3 == 6'h0F) || (op3 == 6'h1D) ||
           (op3 == 6'h1F) || (op3 == 6'h3C) || (op3 == 6'h3E);
  endfunction

  function automatic iclass_t classify(input logic [1:0] op, input logic [5:0] op3);
    iclass_t c;
    if (op != 2'b11)                 c = CLS_PLAIN;
    else if (is_atomic(op3))         c = CLS_MEM;
    else if (op3[3:2] != 2'b01)      c = CLS_MEM;
    else if (op3[1:0] == 2'b11)      c = CLS_ST_DOUBLE;
    else                             c = CLS_ST_SMALL;
    return c;
  endfunction

  function automatic logic is_store(input iclass_t c);
    return (c == CLS_ST_SMALL) || (c == CLS_ST_DOUBLE);
  endfunction

  function automatic logic hazard(input iclass_t cur, input iclass_t last,
                                  input iclass_t prev);
    logic pat_dbl;
    logic pat_gap;
    pat_dbl = (last == CLS_ST_DOUBLE);
    pat_gap = (last == CLS_PLAIN) && (prev == CLS_ST_SMALL);
    return is_store(cur) && (pat_dbl || pat_gap);
  endfunction

endpackage

// File: rtl/stg_decode.sv
module stg_decode
  import stg_pkg::*;
(
  input  logic [1:0] op,
  input  logic [5:0] op3,
  output iclass_t    cls,
  output logic       store
);
  always_comb begin
    cls   = classify(op, op3);
    store = is_store(cls);
  end
endmodule

// File: rtl/stg_history.sv
module stg_history
  import stg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clear,
  input  logic    push,
  input  iclass_t push_cls,
  output iclass_t last_cls,
  output iclass_t prev_cls
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_cls <= CLS_PLAIN;
      prev_cls <= CLS_PLAIN;
    end else if (clear) begin
      last_cls <= CLS_PLAIN;
      prev_cls <= CLS_PLAIN;
    end else if (push) begin
      last_cls <= push_cls;
      prev_cls <= last_cls;
    end
  end
endmodule

// File: rtl/stg_sat_counter.sv
module stg_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (inc && count != TOP)  count <= count + ONE;
  end
endmodule

// File: rtl/b2b_store_guard.sv
module b2b_store_guard
  import stg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IW-1:0]    in_instr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [IW-1:0]    out_instr,
  output logic             out_bubble,
  output logic [CNT_W-1:0] bubble_count
);
  iclass_t in_cls;
  logic    in_is_store;
  iclass_t last_cls;
  iclass_t prev_cls;
  logic    need_bubble;
  logic    xfer;
  logic    bubble_fire;
  iclass_t push_cls;

  stg_decode u_dec (
    .op    (in_instr[31:30]),
    .op3   (in_instr[24:19]),
    .cls   (in_cls),
    .store (in_is_store)
  );

  always_comb begin
    need_bubble = enable && !flush && in_valid && hazard(in_cls, last_cls, prev_cls);
    out_valid   = in_valid;
    out_bubble  = need_bubble;
    out_instr   = need_bubble ? BUBBLE_WORD : in_instr;
    in_ready    = out_ready && !need_bubble;
    xfer        = out_valid && out_ready;
    bubble_fire = xfer && need_bubble;
    push_cls    = need_bubble ? CLS_PLAIN : in_cls;
  end

  stg_history u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (flush),
    .push     (xfer),
    .push_cls (push_cls),
    .last_cls (last_cls),
    .prev_cls (prev_cls)
  );

  stg_sat_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (bubble_fire),
    .count (bubble_count)
  );
endmodule

// File: rtl/stg_checks.sv
module stg_checks
  import stg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             flush,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IW-1:0]    in_instr,
  input logic             out_valid,
  input logic             out_ready,
  input logic [IW-1:0]    out_instr,
  input logic             out_bubble,
  input logic [CNT_W-1:0] bubble_count,
  input logic             in_is_store
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assert_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (out_instr == in_instr && !out_bubble && in_ready == out_ready));

  assert_bubble_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_bubble |-> (!in_ready && out_instr == BUBBLE_WORD && in_valid));

  assert_bubble_on_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_bubble |-> in_is_store);

  assert_single_bubble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_bubble && out_ready) |=> !out_bubble);

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_bubble);

  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == in_valid);

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_bubble && bubble_count != TOP)
      |=> bubble_count == $past(bubble_count) + 1'b1);

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_ready && out_bubble) |=> $stable(bubble_count));

  assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bubble_count == TOP) |=> (bubble_count == TOP));
endmodule

bind b2b_store_guard stg_checks #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .flush        (flush),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_instr     (in_instr),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_instr    (out_instr),
  .out_bubble   (out_bubble),
  .bubble_count (bubble_count),
  .in_is_store  (in_is_store)
);

// File: tb/sim_b2b_store_guard.sv
module sim_b2b_store_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NOPW   = 32'h0100_0000;
  localparam logic [31:0] ALU    = 32'h8200_0000;
  localparam logic [31:0] LD     = 32'hC000_0000;
  localparam logic [31:0] ST     = 32'hC020_0000;
  localparam logic [31:0] STB    = 32'hC028_0000;
  localparam logic [31:0] STH    = 32'hC030_0000;
  localparam logic [31:0] STD    = 32'hC038_0000;
  localparam logic [31:0] STA    = 32'hC0A0_0000;
  localparam logic [31:0] STDA   = 32'hC0B8_0000;
  localparam logic [31:0] STF    = 32'hC120_0000;
  localparam logic [31:0] STDF   = 32'hC138_0000;
  localparam logic [31:0] SWAP   = 32'hC078_0000;
  localparam logic [31:0] CASA   = 32'hC1E0_0000;
  localparam logic [31:0] LDSTUB = 32'hC068_0000;

  // {expect bubble, instruction}; comments give the history rule exercised
  localparam logic [32:0] VEC [26] = '{
    {1'b0, ST},     // R11 first store after reset
    {1'b0, ALU},
    {1'b1, ST},     // R2 word store, one alu, store
    {1'b0, STD},    // R6 word store then store
    {1'b1, ST},     // R3 doubleword then store
    {1'b0, ALU},
    {1'b0, ALU},
    {1'b0, ST},     // R6 two alu between
    {1'b0, ALU},
    {1'b1, STH},    // R2 halfword second store
    {1'b0, LD},
    {1'b0, STF},    // R5 load before store
    {1'b0, SWAP},   // R5 atomic is not a second store
    {1'b0, ALU},
    {1'b0, STA},    // R5 atomic in older slot
    {1'b0, ALU},
    {1'b0, CASA},   // R5 atomic after word store and alu
    {1'b0, STDF},
    {1'b1, STA},    // R3 fp doubleword then ASI store
    {1'b0, STDA},
    {1'b1, STB},    // R3 ASI doubleword then byte store
    {1'b0, ALU},
    {1'b1, STDF},   // R2 R1 byte store is word-or-smaller
    {1'b0, LDSTUB},
    {1'b0, ST},
    {1'b0, ST}      // R6 back-to-back word stores
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_bubble;
  logic [31:0] out_instr;
  logic [15:0] bubble_count;
  logic        s_in_ready, s_out_valid, s_out_bubble;
  logic [31:0] s_out_instr;
  logic [2:0]  s_count;

  int tests = 0;
  int fails = 0;
  int exp_bubbles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  b2b_store_guard u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr),
    .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
    .out_bubble(out_bubble), .bubble_count(bubble_count)
  );

  b2b_store_guard #(.CNT_W(3)) u1 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .flush(flush),
    .in_valid(in_valid), .in_ready(s_in_ready), .in_instr(in_instr),
    .out_valid(s_out_valid), .out_ready(out_ready), .out_instr(s_out_instr),
    .out_bubble(s_out_bubble), .bubble_count(s_count)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] ins, input bit exp_bub, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = ins;
    #1;
    chk(out_bubble == exp_bub, req, {31'd0, out_bubble}, {31'd0, exp_bub});
    if (exp_bub) begin
      exp_bubbles++;
      chk(out_instr == NOPW && !in_ready, {req, " R4 bubble word"}, out_instr, NOPW);
      @(negedge clk);
      #1;
      chk(!out_bubble && out_instr == ins && in_ready, {req, " R4 store follows"},
          out_instr, ins);
    end else begin
      chk(out_instr == ins && in_ready == out_ready, {req, " passthrough"}, out_instr, ins);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk(bubble_count == 16'd0, "R11 counter after reset", {16'd0, bubble_count}, 32'd0);
    chk(!out_valid && !out_bubble, "R10 idle outputs", {31'd0, out_valid}, 32'd0);

    // R1 R2 R3 R5 R6 table walk
    for (int i = 0; i < 26; i++)
      send(VEC[i][31:0], VEC[i][32], $sformatf("R2/R3/R5/R6 vec%0d", i));
    idle();
    #1;
    chk(bubble_count == 16'(exp_bubbles), "R9 count after table",
        {16'd0, bubble_count}, exp_bubbles);

    // R10 stall holds the bubble and the history
    send(ALU, 1'b0, "R10 alu before stall");
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_instr = ST;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(out_bubble && !in_ready && out_instr == NOPW, "R10 bubble held",
          out_instr, NOPW);
      chk(bubble_count == 16'(exp_bubbles), "R10 count frozen",
          {16'd0, bubble_count}, exp_bubbles);
      @(negedge clk);
    end
    out_ready = 1'b1;
    exp_bubbles++;
    @(negedge clk);
    #1;
    chk(!out_bubble && out_instr == ST, "R4 store after held bubble", out_instr, ST);
    chk(bubble_count == 16'(exp_bubbles), "R9 count after stall",
        {16'd0, bubble_count}, exp_bubbles);
    idle();

    // R7 disabled pass-through
    enable = 1'b0;
    send(STD, 1'b0, "R7 disabled doubleword");
    send(ST, 1'b0, "R7 disabled store");
    send(ALU, 1'b0, "R7 disabled alu");
    send(ST, 1'b0, "R7 disabled store");
    idle();
    enable = 1'b1;

    // R8 flush between doubleword and store
    send(STD, 1'b0, "R8 doubleword");
    @(negedge clk);
    in_valid = 1'b0;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    send(ST, 1'b0, "R8 store after flush");
    send(STD, 1'b0, "R8 doubleword again");
    send(ST, 1'b1, "R3 control without flush");
    idle();
    #1;
    chk(bubble_count == 16'(exp_bubbles), "R9 final count",
        {16'd0, bubble_count}, exp_bubbles);
    chk(s_count == 3'd7, "R9 narrow counter saturates", {29'd0, s_count}, 32'd7);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule